// File: doc/BRIEF.md
# Interrupt Pending and Enable State Bank

This block keeps the per-source state that an interrupt distributor needs before any priority is looked at: for every interrupt ID and every CPU it holds an enable bit, a pending bit and the last sampled input level. It also holds a model bit and an edge/level bit for each ID. The IDs below 32 are private: each CPU has its own input line, its own enable and its own pending copy. The IDs from 32 upward are shared: a single input line drives them, and a per-source CPU target mask decides which CPUs receive the pending bit.

Software changes the state through byte-wide register writes. Each write names an operation (set-enable, clear-enable, set-pending, clear-pending or configure), a byte index and the writing CPU. A separate 32-bit software-interrupt write raises pending for one ID on a set of CPUs chosen by a filter field. A small target-mask port loads the CPU mask of each shared source. The block drives flat enable and pending vectors, one slice of `NUM_IRQ` bits per CPU, to a priority selector downstream. It also drives the configuration vectors.

Top module: `irq_pend_core`

## Requirements
- R1: After reset, IDs 0 to 15 are enabled for every CPU and all other enables are 0. Every pending bit is 0. The edge bit is 1 for IDs 0 to 31 and 0 above. Every model bit is 0. `wr_err` is 0.
- R2: A rising input line sets the stored level. The same clock edge sets pending for the routed CPUs if the ID is edge-configured, or if it is already enabled. A falling line clears only the stored level, which a later set-enable then finds low.
- R3: Byte writes of set-enable or clear-enable to bytes 0 and 1 (IDs 0 to 15) behave as all-ones and all-zeros respectively, so those IDs stay enabled.
- R4: Configuration byte k covers IDs 4k to 4k+3. ID 4k+j uses data bit 2j as the model bit and bit 2j+1 as the edge bit (1 = edge-triggered).
- R5: Configuration writes to IDs below 32 have every edge bit forced to 1. The model bits are written normally.
- R6: Setting the enable of a level-configured ID whose stored level is high also sets its pending bit for the routed CPUs.
- R7: A clear-pending write (byte k, bit b, ID 8k+b) clears that ID's pending bit on every CPU.
- R8: The software-interrupt word carries the ID in bits [9:0], the CPU list in bits [23:16] and the filter in bits [25:24]. Filter 0 targets the listed CPUs. Filter 1 targets all CPUs except the writer. Filter 2 targets the writer only. Filter 3 targets all CPUs.
- R9: Pending set by a shared line or by a set-pending or set-enable write goes to the CPUs in that source's target mask. For a private ID, a line sets only its own CPU, and a write sets only the writer.
- R10: If a pending set and a clear-pending write hit the same bit in one cycle, the bit ends set.
- R11: A register byte write, software-interrupt write or target write that addresses an ID at or above `NUM_IRQ` changes no state. It raises `wr_err` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_priv | input | NUM_CPU*32 | Private input lines, CPU c at bits c*32+id |
| src_shr | input | NUM_IRQ-32 | Shared input lines, ID 32+s at bit s |
| cpu_sel | input | CPU_W | Index of the CPU issuing the current write |
| reg_we | input | 1 | Register byte write strobe |
| reg_op | input | 3 | 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 configure |
| reg_byte | input | 8 | Byte index of the write |
| reg_wdata | input | 8 | Write data byte |
| sgi_we | input | 1 | Software-interrupt write strobe |
| sgi_wdata | input | 32 | Software-interrupt word |
| tgt_we | input | 1 | Target mask write strobe |
| tgt_id | input | 10 | Shared ID whose mask is written |
| tgt_mask | input | NUM_CPU | New CPU target mask |
| en_vec | output | NUM_CPU*NUM_IRQ | Enable bits, CPU c at bits c*NUM_IRQ+id |
| pend_vec | output | NUM_CPU*NUM_IRQ | Pending bits, same layout |
| model_vec | output | NUM_IRQ | Model bit per ID |
| edge_vec | output | NUM_IRQ | Edge-triggered bit per ID |
| wr_err | output | 1 | One-cycle flag for a dropped write |

## Verification
The two functions that can meet in one cycle are a pending set caused by a rising input line and a clear-pending register write to the same ID. The bench first lowers a shared edge-configured line so the stored level is low. At one falling clock edge it then raises the line and issues the clear-pending byte write. At the next sampling point it expects the pending bit on the targeted CPU to be set and the bit on the other CPU to stay clear. An internal property also checks that a pending bit only ever falls in a cycle after a clear was requested for it.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int PRIV_IDS   = 32;
    localparam int LOCKED_IDS = 16;
    localparam int MAX_CPUS   = 8;
    localparam int ID_FIELD_W = 10;

    typedef enum logic [2:0] {
        OP_SET_EN   = 3'd0,
        OP_CLR_EN   = 3'd1,
        OP_SET_PEND = 3'd2,
        OP_CLR_PEND = 3'd3,
        OP_CFG      = 3'd4
    } reg_op_e;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } sgi_flt_e;

    typedef struct packed {
        logic [5:0]            spare_hi;
        sgi_flt_e              flt;
        logic [7:0]            cpu_list;
        logic [5:0]            spare_lo;
        logic [ID_FIELD_W-1:0] id;
    } sgi_word_t;

    function automatic logic [MAX_CPUS-1:0] sgi_targets(
        input sgi_flt_e              flt,
        input logic [MAX_CPUS-1:0]   lst,
        input logic [MAX_CPUS-1:0]   self_oh,
        input logic [MAX_CPUS-1:0]   all_oh
    );
        unique case (flt)
            FLT_LIST:   return lst & all_oh;
            FLT_OTHERS: return all_oh & ~self_oh;
            FLT_SELF:   return self_oh;
            default:    return all_oh;
        endcase
    endfunction

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_pend_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               we,
    input  logic [2:0]         op,
    input  logic [7:0]         byte_idx,
    input  logic [7:0]         data,
    output logic [NUM_IRQ-1:0] set_en,
    output logic [NUM_IRQ-1:0] clr_en,
    output logic [NUM_IRQ-1:0] set_pend,
    output logic [NUM_IRQ-1:0] clr_pend,
    output logic [NUM_IRQ-1:0] cfg_we,
    output logic [NUM_IRQ-1:0] cfg_model,
    output logic [NUM_IRQ-1:0] cfg_edge,
    output logic               bad
);
    reg_op_e op_e;
    logic    byte_grp;
    logic    cfg_grp;

    assign op_e     = reg_op_e'(op);
    assign byte_grp = we && (op <= 3'd3);
    assign cfg_grp  = we && (op_e == OP_CFG);
    assign bad      = (byte_grp && (32'(byte_idx) * 8 >= NUM_IRQ))
                   || (cfg_grp  && (32'(byte_idx) * 4 >= NUM_IRQ));

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
        localparam int BI = i / 8;
        localparam int BB = i % 8;
        localparam int CI = i / 4;
        localparam int CB = i % 4;
        logic hit;
        logic cfg_hit;

        assign hit     = byte_grp && (32'(byte_idx) == BI);
        assign cfg_hit = cfg_grp  && (32'(byte_idx) == CI);

        if (i < LOCKED_IDS) begin : g_locked
            assign set_en[i] = hit && (op_e == OP_SET_EN);
            assign clr_en[i] = 1'b0;
        end else begin : g_free
            assign set_en[i] = hit && (op_e == OP_SET_EN) && data[BB];
            assign clr_en[i] = hit && (op_e == OP_CLR_EN) && data[BB];
        end

        assign set_pend[i]  = hit && (op_e == OP_SET_PEND) && data[BB];
        assign clr_pend[i]  = hit && (op_e == OP_CLR_PEND) && data[BB];
        assign cfg_we[i]    = cfg_hit;
        assign cfg_model[i] = data[2*CB];
        if (i < PRIV_IDS) begin : g_force_edge
            assign cfg_edge[i] = 1'b1;
        end else begin : g_cfg_edge
            assign cfg_edge[i] = data[2*CB+1];
        end
    end

endmodule

// File: rtl/irq_sgi_decode.sv
module irq_sgi_decode
    import irq_pend_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64
) (
    input  logic               we,
    input  logic [31:0]        word,
    input  logic [NUM_CPU-1:0] writer_oh,
    output logic [NUM_IRQ-1:0] id_oh,
    output logic [NUM_CPU-1:0] cpu_mask,
    output logic               bad
);
    localparam logic [MAX_CPUS-1:0] ALL_OH = {MAX_CPUS{1'b1}} >> (MAX_CPUS - NUM_CPU);

    sgi_word_t           w;
    logic [MAX_CPUS-1:0] mask_full;

    assign w         = sgi_word_t'(word);
    assign mask_full = sgi_targets(w.flt, w.cpu_list, MAX_CPUS'(writer_oh), ALL_OH);
    assign cpu_mask  = mask_full[NUM_CPU-1:0];
    assign bad       = we && (32'(w.id) >= NUM_IRQ);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
        assign id_oh[i] = we && (32'(w.id) == i);
    end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import irq_pend_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_CPU*PRIV_IDS-1:0]          src_priv,
    input  logic [NUM_IRQ-PRIV_IDS-1:0]          src_shr,
    input  logic [(NUM_IRQ-PRIV_IDS)*NUM_CPU-1:0] tgt_flat,
    input  logic [NUM_CPU-1:0]                   writer_oh,
    input  logic [NUM_IRQ-1:0]                   set_en,
    input  logic [NUM_IRQ-1:0]                   clr_en,
    input  logic [NUM_IRQ-1:0]                   set_pend,
    input  logic [NUM_IRQ-1:0]                   clr_pend,
    input  logic [NUM_IRQ-1:0]                   cfg_we,
    input  logic [NUM_IRQ-1:0]                   cfg_model,
    input  logic [NUM_IRQ-1:0]                   cfg_edge,
    input  logic [NUM_IRQ-1:0]                   sgi_id_oh,
    input  logic [NUM_CPU-1:0]                   sgi_cpu,
    output logic [NUM_CPU*NUM_IRQ-1:0]           en_q,
    output logic [NUM_CPU*NUM_IRQ-1:0]           pend_q,
    output logic [NUM_IRQ-1:0]                   model_q,
    output logic [NUM_IRQ-1:0]                   edge_q
);
    localparam int TOTAL = NUM_CPU * NUM_IRQ;

    logic [TOTAL-1:0] lvl_q;
    logic [TOTAL-1:0] clr_rep;

    assign clr_rep = {NUM_CPU{clr_pend}};

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                model_q[i] <= 1'b0;
                edge_q[i]  <= (i < PRIV_IDS);
            end else if (cfg_we[i]) begin
                model_q[i] <= cfg_model[i];
                edge_q[i]  <= cfg_edge[i];
            end
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
            localparam int K = c * NUM_IRQ + i;
            logic line;
            logic route;
            logic own;
            logic set_any;

            if (i < PRIV_IDS) begin : g_priv
                assign line  = src_priv[c*PRIV_IDS + i];
                assign route = 1'b1;
                assign own   = writer_oh[c];
            end else begin : g_shr
                assign line  = src_shr[i - PRIV_IDS];
                assign route = tgt_flat[(i - PRIV_IDS)*NUM_CPU + c];
                assign own   = 1'b1;
            end

            assign set_any = (line && !lvl_q[K] && route && (edge_q[i] || en_q[K]))
                          || (set_en[i] && own && route && !edge_q[i] && lvl_q[K])
                          || (set_pend[i] && own && route)
                          || (sgi_id_oh[i] && sgi_cpu[c]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q[K]   <= (i < LOCKED_IDS);
                    pend_q[K] <= 1'b0;
                    lvl_q[K]  <= 1'b0;
                end else begin
                    en_q[K]   <= (en_q[K] && !(clr_en[i] && own)) || (set_en[i] && own);
                    pend_q[K] <= (pend_q[K] && !clr_pend[i]) || set_any;
                    lvl_q[K]  <= line;
                end
            end
        end
    end

    AST_PEND_FALLS_ON_CLR: assert property (@(posedge clk) disable iff (rst)
        (|pend_q) |=> (($past(pend_q) & ~pend_q & ~$past(clr_rep)) == '0)); // R7

endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core
    import irq_pend_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 64,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NSHR   = NUM_IRQ - PRIV_IDS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CPU*PRIV_IDS-1:0] src_priv,
    input  logic [NSHR-1:0]             src_shr,
    input  logic [CPU_W-1:0]            cpu_sel,
    input  logic                        reg_we,
    input  logic [2:0]                  reg_op,
    input  logic [7:0]                  reg_byte,
    input  logic [7:0]                  reg_wdata,
    input  logic                        sgi_we,
    input  logic [31:0]                 sgi_wdata,
    input  logic                        tgt_we,
    input  logic [ID_FIELD_W-1:0]       tgt_id,
    input  logic [NUM_CPU-1:0]          tgt_mask,
    output logic [NUM_CPU*NUM_IRQ-1:0]  en_vec,
    output logic [NUM_CPU*NUM_IRQ-1:0]  pend_vec,
    output logic [NUM_IRQ-1:0]          model_vec,
    output logic [NUM_IRQ-1:0]          edge_vec,
    output logic                        wr_err
);
    logic [NUM_CPU-1:0]      writer_oh;
    logic [NUM_IRQ-1:0]      set_en, clr_en, set_pend, clr_pend;
    logic [NUM_IRQ-1:0]      cfg_we, cfg_model, cfg_edge;
    logic [NUM_IRQ-1:0]      sgi_id_oh;
    logic [NUM_CPU-1:0]      sgi_cpu;
    logic                    reg_bad, sgi_bad, tgt_bad;
    logic [NSHR*NUM_CPU-1:0] tgt_flat;
    logic                    locked_all;

    assign writer_oh = NUM_CPU'(1) << cpu_sel;
    assign tgt_bad   = tgt_we && (32'(tgt_id) >= NUM_IRQ);

    irq_wr_decode #(.NUM_IRQ(NUM_IRQ)) u_wr (
        .we(reg_we), .op(reg_op), .byte_idx(reg_byte), .data(reg_wdata),
        .set_en(set_en), .clr_en(clr_en), .set_pend(set_pend), .clr_pend(clr_pend),
        .cfg_we(cfg_we), .cfg_model(cfg_model), .cfg_edge(cfg_edge), .bad(reg_bad)
    );

    irq_sgi_decode #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_sgi (
        .we(sgi_we), .word(sgi_wdata), .writer_oh(writer_oh),
        .id_oh(sgi_id_oh), .cpu_mask(sgi_cpu), .bad(sgi_bad)
    );

    for (genvar s = 0; s < NSHR; s++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst) begin
                tgt_flat[s*NUM_CPU +: NUM_CPU] <= '0;
            end else if (tgt_we && (32'(tgt_id) == s + PRIV_IDS)) begin
                tgt_flat[s*NUM_CPU +: NUM_CPU] <= tgt_mask;
            end
        end
    end

    irq_state_bank #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_bank (
        .clk(clk), .rst(rst), .src_priv(src_priv), .src_shr(src_shr),
        .tgt_flat(tgt_flat), .writer_oh(writer_oh),
        .set_en(set_en), .clr_en(clr_en), .set_pend(set_pend), .clr_pend(clr_pend),
        .cfg_we(cfg_we), .cfg_model(cfg_model), .cfg_edge(cfg_edge),
        .sgi_id_oh(sgi_id_oh), .sgi_cpu(sgi_cpu),
        .en_q(en_vec), .pend_q(pend_vec), .model_q(model_vec), .edge_q(edge_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= reg_bad || sgi_bad || tgt_bad;
    end

    always_comb begin
        locked_all = 1'b1;
        for (int c = 0; c < NUM_CPU; c++) begin
            locked_all = locked_all && (&en_vec[c*NUM_IRQ +: LOCKED_IDS]);
        end
    end

    AST_LOCKED_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_op == 3'd1 && reg_byte < 8'd2) |=> locked_all); // R3

    AST_SGI_SELF_SETS: assert property (@(posedge clk) disable iff (rst)
        (sgi_we && sgi_wdata[25:24] == 2'd2 && 32'(sgi_wdata[9:0]) < NUM_IRQ)
        |=> pend_vec[int'($past(cpu_sel))*NUM_IRQ + int'($past(sgi_wdata[9:0]))]); // R8

    AST_ERR_ON_RANGE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_op <= 3'd3 && 32'(reg_byte) * 8 >= NUM_IRQ) |=> wr_err); // R11

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(reg_we || sgi_we || tgt_we) |=> !wr_err); // R11

endmodule

// File: tb/sim_irq_pend_core.sv
`timescale 1ns/1ps
module sim_irq_pend_core;
    localparam int NC = 2;
    localparam int NI = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic [NC*32-1:0] src_priv;
    logic [NI-33:0]  src_shr;
    logic [0:0]      cpu_sel;
    logic            reg_we;
    logic [2:0]      reg_op;
    logic [7:0]      reg_byte, reg_wdata;
    logic            sgi_we;
    logic [31:0]     sgi_wdata;
    logic            tgt_we;
    logic [9:0]      tgt_id;
    logic [NC-1:0]   tgt_mask;
    logic [NC*NI-1:0] en_vec, pend_vec;
    logic [NI-1:0]   model_vec, edge_vec;
    logic            wr_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [NC*NI-1:0] snap;

    always #2 clk = ~clk;

    irq_pend_core #(.NUM_CPU(NC), .NUM_IRQ(NI)) u0 (
        .clk(clk), .rst(rst), .src_priv(src_priv), .src_shr(src_shr), .cpu_sel(cpu_sel),
        .reg_we(reg_we), .reg_op(reg_op), .reg_byte(reg_byte), .reg_wdata(reg_wdata),
        .sgi_we(sgi_we), .sgi_wdata(sgi_wdata), .tgt_we(tgt_we), .tgt_id(tgt_id),
        .tgt_mask(tgt_mask), .en_vec(en_vec), .pend_vec(pend_vec),
        .model_vec(model_vec), .edge_vec(edge_vec), .wr_err(wr_err)
    );

    // writer, software-interrupt word, expected {cpu1,cpu0} pending for that ID
    localparam logic [34:0] SGI_TAB [7] = '{
        {1'b0, 6'd0, 2'd0, 8'h02, 6'd0, 10'd3,  2'b10},
        {1'b0, 6'd0, 2'd1, 8'h00, 6'd0, 10'd4,  2'b10},
        {1'b1, 6'd0, 2'd1, 8'h00, 6'd0, 10'd4,  2'b01},
        {1'b1, 6'd0, 2'd2, 8'h00, 6'd0, 10'd7,  2'b10},
        {1'b0, 6'd0, 2'd3, 8'h00, 6'd0, 10'd9,  2'b11},
        {1'b0, 6'd0, 2'd0, 8'hFF, 6'd0, 10'd40, 2'b11},
        {1'b1, 6'd0, 2'd0, 8'h00, 6'd0, 10'd2,  2'b00}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] pbits(input int id);
        return {pend_vec[NI + id], pend_vec[id]};
    endfunction

    task automatic reg_wr(input logic [2:0] op, input logic [7:0] b, input logic [7:0] d, input logic w);
        @(negedge clk);
        reg_we = 1'b1; reg_op = op; reg_byte = b; reg_wdata = d; cpu_sel = w;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic sgi_wr(input logic [31:0] d, input logic w);
        @(negedge clk);
        sgi_we = 1'b1; sgi_wdata = d; cpu_sel = w;
        @(negedge clk);
        sgi_we = 1'b0;
    endtask

    task automatic tgt_wr(input logic [9:0] id, input logic [NC-1:0] m);
        @(negedge clk);
        tgt_we = 1'b1; tgt_id = id; tgt_mask = m;
        @(negedge clk);
        tgt_we = 1'b0;
    endtask

    task automatic shr_line(input int id, input logic v);
        @(negedge clk);
        src_shr[id-32] = v;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; src_priv = '0; src_shr = '0; cpu_sel = '0;
        reg_we = 1'b0; reg_op = '0; reg_byte = '0; reg_wdata = '0;
        sgi_we = 1'b0; sgi_wdata = '0; tgt_we = 1'b0; tgt_id = '0; tgt_mask = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 en cpu0", en_vec[63:0], 64'h0000_0000_0000_FFFF);
        chk("R1 en cpu1", en_vec[127:64], 64'h0000_0000_0000_FFFF);
        chk("R1 pending", {63'd0, |pend_vec}, 64'd0);
        chk("R1 edge", edge_vec, 64'h0000_0000_FFFF_FFFF);
        chk("R1 model", model_vec, 64'd0);
        chk("R1 err", {63'd0, wr_err}, 64'd0);

        // R8 software-interrupt table
        for (int k = 0; k < 7; k++) begin
            int id;
            id = int'(SGI_TAB[k][11:2]);
            reg_wr(3'd3, 8'(id / 8), 8'(1 << (id % 8)), 1'b0);
            sgi_wr(SGI_TAB[k][33:2], SGI_TAB[k][34]);
            chk($sformatf("R8 sgi entry %0d", k), {62'd0, pbits(id)}, {62'd0, SGI_TAB[k][1:0]});
        end
        reg_wr(3'd3, 8'd0, 8'hFF, 1'b0);
        reg_wr(3'd3, 8'd1, 8'hFF, 1'b0);
        reg_wr(3'd3, 8'd5, 8'hFF, 1'b0);
        chk("R7 clear all", {63'd0, |pend_vec}, 64'd0);

        // R4 configuration encoding
        reg_wr(3'd4, 8'd10, 8'h63, 1'b0);
        chk("R4 model 43..40", {60'd0, model_vec[43:40]}, 64'h9);
        chk("R4 edge 43..40", {60'd0, edge_vec[43:40]}, 64'h5);

        // R5 private IDs stay edge
        reg_wr(3'd4, 8'd0, 8'h00, 1'b0);
        chk("R5 edge forced", {56'd0, model_vec[3:0], edge_vec[3:0]}, 64'h0F);
        reg_wr(3'd4, 8'd0, 8'h55, 1'b0);
        chk("R5 model written", {56'd0, model_vec[3:0], edge_vec[3:0]}, 64'hFF);

        // R3 locked enables
        reg_wr(3'd1, 8'd0, 8'hFF, 1'b0);
        reg_wr(3'd1, 8'd1, 8'hFF, 1'b1);
        chk("R3 locked en", {32'd0, en_vec[NI +: 16], en_vec[15:0]}, 64'hFFFF_FFFF);

        // R9 private enable goes to the writer only
        reg_wr(3'd0, 8'd2, 8'h01, 1'b1);
        chk("R9 private enable", {62'd0, en_vec[NI+16], en_vec[16]}, 64'h2);

        // R2/R9 shared edge source routed by target mask
        tgt_wr(10'd40, 2'b10);
        shr_line(40, 1'b1);
        chk("R9 shared edge routed", {62'd0, pbits(40)}, 64'h2);

        // R2 level source, not enabled: rise does not pend
        tgt_wr(10'd41, 2'b11);
        shr_line(41, 1'b1);
        chk("R2 level disabled rise", {62'd0, pbits(41)}, 64'h0);

        // R6 enabling a raised level source pends it
        reg_wr(3'd0, 8'd5, 8'h02, 1'b0);
        chk("R6 enable pends", {60'd0, en_vec[NI+41], en_vec[41], pbits(41)}, 64'hF);

        // R7 clear-pending on all CPUs
        reg_wr(3'd3, 8'd5, 8'h03, 1'b1);
        chk("R7 clear both cpus", {60'd0, pbits(41), pbits(40)}, 64'h0);

        // R2 falling clears only the level
        shr_line(41, 1'b0);
        chk("R2 fall no pend", {62'd0, pbits(41)}, 64'h0);
        reg_wr(3'd0, 8'd5, 8'h02, 1'b0);
        chk("R2 level cleared", {62'd0, pbits(41)}, 64'h0);
        shr_line(41, 1'b1);
        chk("R2 enabled level rise", {62'd0, pbits(41)}, 64'h3);

        // R9 private line goes to its own CPU
        @(negedge clk);
        src_priv[20] = 1'b1;
        @(negedge clk);
        chk("R9 private line", {62'd0, pbits(20)}, 64'h1);

        // R9 set-pending writes
        tgt_wr(10'd42, 2'b01);
        reg_wr(3'd2, 8'd5, 8'h04, 1'b1);
        chk("R9 shared set-pend", {62'd0, pbits(42)}, 64'h1);
        reg_wr(3'd2, 8'd3, 8'h02, 1'b1);
        chk("R9 private set-pend", {62'd0, pbits(25)}, 64'h2);

        // R10 line rise and clear-pending together
        shr_line(40, 1'b0);
        chk("R10 precondition", {62'd0, pbits(40)}, 64'h0);
        @(negedge clk);
        src_shr[40-32] = 1'b1;
        reg_we = 1'b1; reg_op = 3'd3; reg_byte = 8'd5; reg_wdata = 8'h01;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R10 set beats clear", {62'd0, pbits(40)}, 64'h2);

        // R11 out-of-range writes
        snap = pend_vec;
        reg_wr(3'd2, 8'd8, 8'hFF, 1'b0);
        chk("R11 reg err", {63'd0, wr_err}, 64'd1);
        chk("R11 reg no effect", {63'd0, pend_vec !== snap}, 64'd0);
        @(negedge clk);
        chk("R11 err one cycle", {63'd0, wr_err}, 64'd0);
        reg_wr(3'd4, 8'd16, 8'hFF, 1'b0);
        chk("R11 cfg err", {63'd0, wr_err}, 64'd1);
        sgi_wr({6'd0, 2'd3, 8'h00, 6'd0, 10'd70}, 1'b0);
        chk("R11 sgi err", {63'd0, wr_err}, 64'd1);
        chk("R11 sgi no effect", {63'd0, pend_vec !== snap}, 64'd0);
        tgt_wr(10'd64, 2'b11);
        chk("R11 tgt err", {63'd0, wr_err}, 64'd1);
        reg_wr(3'd3, 8'd7, 8'h00, 1'b0);
        chk("R11 in-range no err", {63'd0, wr_err}, 64'd0);

        summary();
        $finish;
    end

endmodule